// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block tracks load-locked / store-conditional reservations for a set of execution contexts that share one memory. Every context owns one reservation: a granule tag plus a valid flag. A load-locked access records the granule of its address for the issuing context. A later store-conditional from that context succeeds only while the flag is still set and the granule still matches.

Any store that actually writes memory removes the reservation of every context that holds the written granule. A store that writes memory is a plain store, a successful store-conditional, or an uncacheable store-conditional. The issuing context's own reservation is removed as well.

The monitor also counts consecutive failed store-conditionals per context and raises a one-cycle warning pulse every `WARN_PERIOD` failures. This flags a context that appears to be livelocked. The block handles one access per cycle and carries no data. The memory side uses the success bit to decide whether to perform a conditional store.

Top module: `resv_monitor`

## Requirements
- R1: An access with `accValid`=1 and `accType`=2'b01 (load-locked) stores the granule `accAddr[ADDR_W-1:GRAN_BITS]` as the reservation of context `accCtx` and sets its lock flag. Other contexts are untouched.
- R2: A cacheable store-conditional (`accType`=2'b10, `accUncached`=0) gives `scDone`=1 in the following cycle. In that cycle `scSuccess`=1 exactly when the issuing context's lock flag was set and its reservation granule equals the store's granule; the low `GRAN_BITS` address bits are ignored.
- R3: A failed store-conditional clears only the issuing context's lock flag. Reservations of all other contexts survive.
- R4: A successful store-conditional clears the lock flag of every context, the issuer included, whose reservation granule equals the store granule.
- R5: A plain store (`accType`=2'b11) clears the lock flag of every context whose reservation granule matches its address. Contexts holding other granules keep their reservations.
- R6: Each context keeps a failure count. A failed cacheable store-conditional increments it, and a successful one sets it to zero. When the count reaches a multiple of `WARN_PERIOD`, `warnPulse[ctx]` is 1 for exactly the cycle in which that failure's `scDone` is 1.
- R7: An uncacheable store-conditional (`accUncached`=1) produces no `scDone` and leaves `scSuccess` at its previous value. It sets the issuer's failure count to zero and clears matching reservations like a plain store.
- R8: After reset all lock flags are clear, all failure counts are zero, and `scDone`, `scSuccess` and `warnPulse` are 0.
- R9: While `accValid`=0, or with `accType`=2'b00, no reservation, count or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accType | input | 2 | 00 none, 01 load-locked, 10 store-conditional, 11 plain store |
| accCtx | input | CTX_W | Issuing context index |
| accAddr | input | ADDR_W | Physical address of the access |
| accUncached | input | 1 | Store-conditional targets uncacheable space |
| scDone | output | 1 | Store-conditional result valid this cycle |
| scSuccess | output | 1 | Result of the last cacheable store-conditional |
| warnPulse | output | NUM_CTX | Per-context consecutive-failure warning pulse |

## Verification
The bench targets several corner cases, each chosen to expose a specific design error:
- A store-conditional whose address differs only below the granule must succeed. A design that compares full addresses would report failure.
- One that differs in the next bit up must fail. A design with a granule that is too wide would report success.
- A failure that leaves a neighbour's reservation alive, followed by that neighbour's success, catches a design that clears on failed conditionals.
- Two contexts holding the same granule, where one succeeds, catch a design that forgets the other context or the issuer itself.
- An uncacheable conditional placed just before the warning threshold must restart the count. A design that does not restart it pulses the warning early, and one that still emits a result shows an unexpected `scDone`.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LL   = 2'b01,
    ACC_SC   = 2'b10,
    ACC_ST   = 2'b11
  } accKind_e;

  // strobes from the control decoder to the per-context datapath
  typedef struct packed {
    logic setLock;   // load-locked from the selected context
    logic clrOwn;    // failed conditional: drop the issuer's flag
    logic clrMatch;  // memory written: drop every matching reservation
    logic cntInc;    // failed conditional: bump issuer's count
    logic cntClr;    // success or uncacheable: restart issuer's count
  } resvStrobe_t;

endpackage

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic [1:0]  accType,
  input  logic        accUncached,
  input  logic        ownHit,
  output resvStrobe_t strobe,
  output logic        scDone,
  output logic        scSuccess
);

  accKind_e kind;
  logic isLl, isSc, isSt, scCached, scUncached;

  assign kind       = accKind_e'(accType);
  assign isLl       = accValid && (kind == ACC_LL);
  assign isSc       = accValid && (kind == ACC_SC);
  assign isSt       = accValid && (kind == ACC_ST);
  assign scCached   = isSc && !accUncached;
  assign scUncached = isSc && accUncached;

  always_comb begin
    strobe          = '0;
    strobe.setLock  = isLl;
    strobe.clrOwn   = scCached && !ownHit;
    strobe.cntInc   = scCached && !ownHit;
    strobe.clrMatch = isSt || scUncached || (scCached && ownHit);
    strobe.cntClr   = scUncached || (scCached && ownHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scDone    <= 1'b0;
      scSuccess <= 1'b0;
    end else begin
      scDone <= scCached;
      if (scCached) scSuccess <= ownHit;
    end
  end

  // R2: a conditional issued without a valid matching reservation reports failure
  a_r2_miss_fails : assert property (@(posedge clk) disable iff (!rstN)
    (scCached && !ownHit) |=> (scDone && !scSuccess));

  // R2: a conditional with a live matching reservation reports success
  a_r2_hit_succeeds : assert property (@(posedge clk) disable iff (!rstN)
    (scCached && ownHit) |=> (scDone && scSuccess));

  // R7: uncacheable conditional produces no result and keeps the old one
  a_r7_uncached_silent : assert property (@(posedge clk) disable iff (!rstN)
    scUncached |=> (!scDone && $stable(scSuccess)));

  // R9: idle cycles never produce a result
  a_r9_idle_quiet : assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !scDone);

endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TAG_W      = ADDR_W - GRAN_BITS,
  localparam int CNT_W      = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CTX_W-1:0]   accCtx,
  input  logic [ADDR_W-1:0]  accAddr,
  input  resvStrobe_t        strobe,
  output logic               ownHit,
  output logic [NUM_CTX-1:0] warnPulse
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARN_PERIOD - 1);

  logic [TAG_W-1:0]   accTag;
  logic [NUM_CTX-1:0] lockFlag;
  logic [NUM_CTX-1:0] tagMatch;
  logic [NUM_CTX-1:0] ctxSel;

  assign accTag = accAddr[ADDR_W-1:GRAN_BITS];

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    logic [TAG_W-1:0] resvTag;
    logic             flagQ;
    logic [CNT_W-1:0] failCnt;
    logic             warnQ;

    assign ctxSel[i]    = (accCtx == CTX_W'(i));
    assign tagMatch[i]  = (resvTag == accTag);
    assign lockFlag[i]  = flagQ;
    assign warnPulse[i] = warnQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resvTag <= '0;
        flagQ   <= 1'b0;
      end else if (strobe.setLock && ctxSel[i]) begin
        resvTag <= accTag;
        flagQ   <= 1'b1;
      end else if (strobe.clrOwn && ctxSel[i]) begin
        flagQ <= 1'b0;
      end else if (strobe.clrMatch && tagMatch[i]) begin
        flagQ <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        failCnt <= '0;
        warnQ   <= 1'b0;
      end else begin
        warnQ <= 1'b0;
        if (ctxSel[i] && strobe.cntClr) begin
          failCnt <= '0;
        end else if (ctxSel[i] && strobe.cntInc) begin
          if (failCnt == CNT_LAST) begin
            failCnt <= '0;
            warnQ   <= 1'b1;
          end else begin
            failCnt <= failCnt + 1'b1;
          end
        end
      end
    end

    // R1: load-locked leaves the issuing context holding a reservation
    a_r1_ll_sets : assert property (@(posedge clk) disable iff (!rstN)
      (strobe.setLock && ctxSel[i]) |=> lockFlag[i]);

    // R4 / R5: a memory write drops every reservation on its granule
    a_r5_match_cleared : assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrMatch && tagMatch[i]) |=> !lockFlag[i]);

    // R3: a failed conditional from another context leaves this flag alone
    a_r3_fail_isolated : assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrOwn && !ctxSel[i]) |=> (lockFlag[i] == $past(lockFlag[i])));

    // R9: with no strobe active, the reservation flag holds
    a_r9_flag_stable : assert property (@(posedge clk) disable iff (!rstN)
      (strobe == '0) |=> $stable(lockFlag[i]));
  end

  always_comb begin
    ownHit = 1'b0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (ctxSel[k] && lockFlag[k] && tagMatch[k]) ownHit = 1'b1;
    end
  end

  // R6: only the single accessing context can ever raise a warning
  a_r6_warn_onehot : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(warnPulse));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CTX     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic [1:0]         accType,
  input  logic [CTX_W-1:0]   accCtx,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic               accUncached,
  output logic               scDone,
  output logic               scSuccess,
  output logic [NUM_CTX-1:0] warnPulse
);

  resvStrobe_t strobe;
  logic        ownHit;

  resv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .accType    (accType),
    .accUncached(accUncached),
    .ownHit     (ownHit),
    .strobe     (strobe),
    .scDone     (scDone),
    .scSuccess  (scSuccess)
  );

  resv_datapath #(
    .NUM_CTX    (NUM_CTX),
    .ADDR_W     (ADDR_W),
    .GRAN_BITS  (GRAN_BITS),
    .WARN_PERIOD(WARN_PERIOD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .accCtx   (accCtx),
    .accAddr  (accAddr),
    .strobe   (strobe),
    .ownHit   (ownHit),
    .warnPulse(warnPulse)
  );

  // R8: outputs are quiet in the first cycle after reset is released
  a_r8_reset_quiet : assert property (@(posedge clk)
    $rose(rstN) |-> (!scDone && !scSuccess && (warnPulse == '0)));

endmodule

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb;

  localparam int NC = 4;
  localparam int AW = 32;
  localparam int WP = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accValid = 1'b0;
  logic [1:0]    accType = 2'b00;
  logic [1:0]    accCtx = '0;
  logic [AW-1:0] accAddr = '0;
  logic          accUncached = 1'b0;
  logic          scDone, scSuccess;
  logic [NC-1:0] warnPulse;

  int nChecks = 0;
  int nFails  = 0;
  int failCnt [NC];
  bit expQ[$];
  logic [NC-1:0] warnQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  resv_monitor #(.NUM_CTX(NC), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(WP)) u_dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accType(accType),
    .accCtx(accCtx), .accAddr(accAddr), .accUncached(accUncached),
    .scDone(scDone), .scSuccess(scSuccess), .warnPulse(warnPulse)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access: drive for one cycle, then idle one cycle
  task automatic access(int ctx, logic [1:0] kind, logic [AW-1:0] addr, bit uc, bit valid = 1'b1);
    @(negedge clk);
    accValid = valid; accType = kind; accCtx = 2'(ctx); accAddr = addr; accUncached = uc;
    @(negedge clk);
    accValid = 1'b0; accType = 2'b00; accUncached = 1'b0;
  endtask

  task automatic ll(int ctx, logic [AW-1:0] addr);
    access(ctx, 2'b01, addr, 1'b0);
  endtask

  task automatic st(int ctx, logic [AW-1:0] addr);
    access(ctx, 2'b11, addr, 1'b0);
  endtask

  // cacheable conditional: push expected result and warning
  task automatic sc(int ctx, logic [AW-1:0] addr, bit expOk, string tag);
    logic [NC-1:0] w = '0;
    if (expOk) failCnt[ctx] = 0;
    else begin
      failCnt[ctx]++;
      if (failCnt[ctx] % WP == 0) w[ctx] = 1'b1;
    end
    @(negedge clk);
    expQ.push_back(expOk); warnQ.push_back(w); tagQ.push_back(tag);
    accValid = 1'b1; accType = 2'b10; accCtx = 2'(ctx); accAddr = addr; accUncached = 1'b0;
    @(negedge clk);
    accValid = 1'b0; accType = 2'b00;
  endtask

  // monitor: pop and compare whenever a result appears
  always @(negedge clk) begin
    if (rstN) begin
      if (scDone) begin
        if (expQ.size() == 0) check(1'b0, "R7 unexpected scDone", 1, 0);
        else begin
          automatic bit e = expQ.pop_front();
          automatic logic [NC-1:0] w = warnQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(scSuccess == e, {t, " scSuccess"}, 32'(scSuccess), 32'(e));
          check(warnPulse == w, {t, " R6 warnPulse"}, 32'(warnPulse), 32'(w));
        end
      end else if (warnPulse != '0) begin
        check(1'b0, "R6 warn without result", 32'(warnPulse), 0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    bit prev;
    for (int i = 0; i < NC; i++) failCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(scDone == 1'b0, "R8 scDone", 32'(scDone), 0);
    check(scSuccess == 1'b0, "R8 scSuccess", 32'(scSuccess), 0);
    check(warnPulse == '0, "R8 warnPulse", 32'(warnPulse), 0);
    sc(0, 32'h0, 1'b0, "R8 no lock after reset");

    // R9: invalid load-locked and idle store are ignored
    access(1, 2'b01, 32'h100, 1'b0, 1'b0);
    sc(1, 32'h100, 1'b0, "R9 invalid ll ignored");
    ll(0, 32'hC000);
    access(2, 2'b11, 32'hC000, 1'b0, 1'b0);
    access(2, 2'b00, 32'hC000, 1'b0);
    sc(0, 32'hC000, 1'b1, "R9 idle store ignored");

    // R1/R2: granule match ignores the low bits
    ll(0, 32'h1000);
    sc(0, 32'h100C, 1'b1, "R2 same granule");
    ll(0, 32'h2000);
    sc(0, 32'h2010, 1'b0, "R2 next granule");
    sc(0, 32'h2000, 1'b0, "R3 own flag cleared");

    // R3: failed conditional leaves the neighbour alone
    ll(1, 32'h3000);
    ll(2, 32'h4000);
    sc(2, 32'h3000, 1'b0, "R3 mismatch fail");
    sc(1, 32'h3008, 1'b1, "R3 neighbour survives");

    // R4: success clears all holders of the granule
    ll(0, 32'h5000);
    ll(1, 32'h5004);
    ll(2, 32'h6000);
    sc(0, 32'h500F, 1'b1, "R4 first winner");
    sc(1, 32'h5000, 1'b0, "R4 other holder cleared");
    sc(0, 32'h5000, 1'b0, "R4 issuer cleared");
    sc(2, 32'h6000, 1'b1, "R4 other granule kept");

    // R5: plain store clears matching reservations only
    ll(3, 32'h7000);
    ll(1, 32'h8000);
    st(0, 32'h7008);
    sc(3, 32'h7000, 1'b0, "R5 store cleared");
    sc(1, 32'h8000, 1'b1, "R5 other kept");

    // R6: repeated failures pulse the warning every WP failures
    for (int k = 0; k < 2 * WP; k++) sc(0, 32'h9000, 1'b0, "R6 failure run");
    ll(0, 32'h9000);
    sc(0, 32'h9000, 1'b1, "R6 success resets");
    for (int k = 0; k < WP - 1; k++) sc(0, 32'h9000, 1'b0, "R6 below threshold");

    // R7: uncacheable conditional
    sc(3, 32'hA000, 1'b0, "R7 prep");
    sc(3, 32'hA000, 1'b0, "R7 prep");
    ll(2, 32'hB000);
    sc(2, 32'hB000, 1'b1, "R7 set result high");
    ll(1, 32'hA000);
    prev = scSuccess;
    access(3, 2'b10, 32'hA004, 1'b1);
    failCnt[3] = 0;
    check(scSuccess == prev, "R7 scSuccess held", 32'(scSuccess), 32'(prev));
    sc(1, 32'hA000, 1'b0, "R7 uncached clears match");
    for (int k = 0; k < WP; k++) sc(3, 32'hA000, 1'b0, "R7 count restarted");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 pending results", 32'(expQ.size()), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule